// File: doc/BRIEF.md
# Programmable Countdown Event Timer

This block is a single event timer channel. It counts down on a free-running one-microsecond tick strobe and raises an interrupt when the count runs out. Software arms it with one 32-bit word that holds three things: an arm flag, a repeat flag and a 29-bit terminal count. The interrupt is raised after the strobe has been seen count+1 times, so a count of zero expires on the first strobe. In single-shot mode the channel disarms itself when it expires. In repeat mode it reloads the same count and keeps running, so it fires every count+1 strobes.

The interrupt is an active-high level. It stays asserted until software writes a one to the acknowledge bit of the second register. If an expiry and an acknowledge fall in the same cycle, the expiry wins. Each channel decodes a byte offset of three bits, so a decoder that sends every eighth byte of the map to the next channel can place several channels side by side at an 8-byte stride.

The control sequencer has three states. `ST_IDLE` means not counting. `ST_ONESHOT` means counting and disarming on expiry. `ST_PERIODIC` means counting and reloading on expiry. The transitions are:
- arm, from any state: a write of the value register with the arm bit set goes to `ST_ONESHOT` or `ST_PERIODIC`, chosen by the repeat bit.
- stop, from any state: a write of the value register with the arm bit clear goes to `ST_IDLE`.
- disarm: an expiry in `ST_ONESHOT` goes to `ST_IDLE`.
- reload: an expiry in `ST_PERIODIC` stays in `ST_PERIODIC`.

Top module: `tmr_channel`

## Requirements
- R1: The value register is at byte offset 0x0. Bit 31 is the arm bit, bit 30 is the repeat bit and bits 28:0 are the terminal count, with a maximum of 0x1fffffff. A read returns the arm bit as the live running state, the repeat bit, and the count as written. Bit 29 and unused bits read 0.
- R2: The countdown advances only on cycles in which `tick_1us` is high. After an arming write with count N, `irq` is low through the first N strobes and high after the (N+1)th strobe.
- R3: A terminal count of 0 expires on the first strobe after arming.
- R4: In single-shot mode, the arm bit reads 0 after expiry. No further interrupt is raised by later strobes.
- R5: In repeat mode, the channel reloads the count on expiry and fires again after every further N+1 strobes. The arm bit stays 1.
- R6: Writing the value register with the arm bit clear (for example, writing zero) stops the countdown, and no interrupt follows.
- R7: `irq` is an active-high level that holds until a control-register write with bit 30 set. A control write with bit 30 clear leaves it unchanged.
- R8: If an expiry and an acknowledge write happen in the same cycle, `irq` stays asserted.
- R9: Rewriting the value register while the channel is counting restarts the countdown from the new count. A strobe in the same cycle as the write is ignored.
- R10: The control register is at byte offset 0x4. A read returns the current remaining count in bits 28:0 and the pending interrupt flag in bit 30. All other bits read 0.
- R11: After reset the channel is in `ST_IDLE`, `irq` is low and both registers read 0.
- R12: Only offsets 0x0 and 0x4 are decoded. Writes to any other offset have no effect, and reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1us | input | 1 | One-cycle strobe at the counting rate |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Byte offset within the channel's 8-byte window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt, active high |

## Verification
The assertions check every cycle that:
- the remaining count never exceeds the programmed count, and stays frozen on cycles without a strobe;
- a repeat-mode expiry reloads the count;
- a single-shot expiry leaves the channel disarmed;
- the interrupt level only rises after an expiry, and only an acknowledge write can lower it, which an expiry in the same cycle overrides.

Only the bench's scenarios can show the end-to-end timing: exactly N+1 strobes to expiry, with random gaps between strobes, and the repeat spacing. The same holds for the restart on rewrite, the stop by writing zero, the readback layout of both registers, and writes to undecoded offsets being ignored.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ONESHOT  = 2'd1,
        ST_PERIODIC = 2'd2
    } tmr_state_e;

    localparam int ARM_BIT  = 31;
    localparam int RPT_BIT  = 30;
    localparam int ACK_BIT  = 30;
    localparam int PEND_BIT = 30;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 29
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              running,
    input  logic              per_q,
    input  logic [CNT_W-1:0]  load_q,
    input  logic [CNT_W-1:0]  count_q,
    input  logic              pend_q,
    output logic              val_wr,
    output logic              new_en,
    output logic              new_per,
    output logic [CNT_W-1:0]  new_load,
    output logic              ack_req,
    output logic [DATA_W-1:0] rdata
);
    import tmr_pkg::*;

    localparam logic [ADDR_W-1:0] VAL_OFS = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] CTL_OFS = ADDR_W'(4);

    logic hit_val, hit_ctl;
    logic unused_wbits;

    assign hit_val = (addr == VAL_OFS);
    assign hit_ctl = (addr == CTL_OFS);

    assign val_wr   = wr_en && hit_val;
    assign new_en   = wdata[ARM_BIT];
    assign new_per  = wdata[RPT_BIT];
    assign new_load = wdata[CNT_W-1:0];
    assign ack_req  = wr_en && hit_ctl && wdata[ACK_BIT];

    assign unused_wbits = ^wdata[DATA_W-3:CNT_W];

    always_comb begin
        rdata = '0;
        if (hit_val) begin
            rdata[ARM_BIT]     = running;
            rdata[RPT_BIT]     = per_q;
            rdata[CNT_W-1:0]   = load_q;
        end else if (hit_ctl) begin
            rdata[PEND_BIT]    = pend_q;
            rdata[CNT_W-1:0]   = count_q;
        end
    end
endmodule

// File: rtl/tmr_fsm.sv
module tmr_fsm #(
    parameter int CNT_W = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              val_wr,
    input  logic              new_en,
    input  logic              new_per,
    input  logic [CNT_W-1:0]  new_load,
    output logic [CNT_W-1:0]  count_q,
    output logic [CNT_W-1:0]  load_q,
    output logic              per_q,
    output logic              running,
    output logic              expire
);
    import tmr_pkg::*;

    tmr_state_e state_q, state_d;
    logic       at_zero;

    assign running = (state_q != ST_IDLE);
    assign at_zero = (count_q == '0);
    assign expire  = running && tick && at_zero && !val_wr;

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (val_wr) begin
            if (!new_en)
                state_d = ST_IDLE;
            else if (new_per)
                state_d = ST_PERIODIC;
            else
                state_d = ST_ONESHOT;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ONESHOT:  if (expire) state_d = ST_IDLE;
                ST_PERIODIC: state_d = ST_PERIODIC;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // datapath outputs: programmed count, mode and remaining count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q  <= '0;
            per_q   <= 1'b0;
            count_q <= '0;
        end else if (val_wr) begin
            load_q  <= new_load;
            per_q   <= new_per;
            count_q <= new_load;
        end else if (expire) begin
            count_q <= load_q;
        end else if (running && tick) begin
            count_q <= count_q - 1'b1;
        end
    end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic ack_req,
    output logic pend_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (expire)
            pend_q <= 1'b1;
        else if (ack_req)
            pend_q <= 1'b0;
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1us,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic              val_wr, new_en, new_per, ack_req;
    logic [CNT_W-1:0]  new_load, count_q, load_q;
    logic              per_q, running, expire, pend_q;

    tmr_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_decode (
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .running  (running),
        .per_q    (per_q),
        .load_q   (load_q),
        .count_q  (count_q),
        .pend_q   (pend_q),
        .val_wr   (val_wr),
        .new_en   (new_en),
        .new_per  (new_per),
        .new_load (new_load),
        .ack_req  (ack_req),
        .rdata    (rdata)
    );

    tmr_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1us),
        .val_wr   (val_wr),
        .new_en   (new_en),
        .new_per  (new_per),
        .new_load (new_load),
        .count_q  (count_q),
        .load_q   (load_q),
        .per_q    (per_q),
        .running  (running),
        .expire   (expire)
    );

    tmr_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire),
        .ack_req (ack_req),
        .pend_q  (pend_q)
    );

    assign irq = pend_q;
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 29
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_1us,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              irq,
    input logic              expire,
    input logic              running,
    input logic              per_q,
    input logic              val_wr,
    input logic [CNT_W-1:0]  count_q,
    input logic [CNT_W-1:0]  load_q
);
    logic ack_wr;
    assign ack_wr = wr_en && (addr == ADDR_W'(4)) && wdata[30];

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= load_q); // R1

    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1us && !val_wr) |=> $stable(count_q)); // R2

    AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !per_q) |=> !running); // R4

    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && per_q) |=> (running && count_q == load_q)); // R5

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack_wr) |=> irq); // R7

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !expire |=> !$rose(irq)); // R7

    AST_EXPIRE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq); // R8
endmodule

bind tmr_channel tmr_channel_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1us (tick_1us),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .irq      (irq),
    .expire   (expire),
    .running  (running),
    .per_q    (per_q),
    .val_wr   (val_wr),
    .count_q  (count_q),
    .load_q   (load_q)
);

// File: tb/test_tmr_channel.sv
`timescale 1ns/1ps
module test_tmr_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1us = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    localparam logic [31:0] ARM = 32'h8000_0000;
    localparam logic [31:0] RPT = 32'h4000_0000;
    localparam logic [31:0] ACK = 32'h4000_0000;

    always #2.5 clk = ~clk;

    tmr_channel i_tmr_channel (
        .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // expected value-register readback from the R1 layout
    function automatic logic [31:0] exp_val(input logic armed, input logic rpt, input logic [28:0] n);
        return {armed, rpt, 1'b0, n};
    endfunction

    // expected control-register readback from the R10 layout
    function automatic logic [31:0] exp_ctl(input logic pend, input logic [28:0] n);
        return {1'b0, pend, 1'b0, n};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, let the posedge take it, return at the next negedge
    task automatic cyc(input logic t, input logic w, input logic [2:0] a, input logic [31:0] d);
        tick_1us = t; wr_en = w; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        tick_1us = 1'b0; wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        addr = a;
        #0.5;
        v = rdata;
    endtask

    task automatic gap();
        int g = $urandom_range(0, 3);
        for (int i = 0; i < g; i++) cyc(1'b0, 1'b0, 3'd0, 32'd0);
    endtask

    task automatic ack();
        cyc(1'b0, 1'b1, 3'd4, ACK);
    endtask

    // single-shot run with random strobe gaps
    task automatic run_oneshot(input int n);
        logic [31:0] v;
        cyc(1'b0, 1'b1, 3'd0, ARM | 32'(n));
        check("R2 armed irq low", {31'd0, irq}, 32'd0);
        for (int k = 1; k <= n + 1; k++) begin
            gap();
            cyc(1'b1, 1'b0, 3'd0, 32'd0);
            if (k <= n) check("R2 before expiry", {31'd0, irq}, 32'd0);
            else        check("R2 at expiry", {31'd0, irq}, 32'd1);
        end
        rd(3'd0, v);
        check("R4 arm bit cleared", v, exp_val(1'b0, 1'b0, 29'(n)));
        ack();
        check("R7 ack clears", {31'd0, irq}, 32'd0);
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check("R11 irq", {31'd0, irq}, 32'd0);
        rd(3'd0, v); check("R11 value reg", v, 32'd0);
        rd(3'd4, v); check("R11 control reg", v, 32'd0);

        // R1 layout, bit 29 dropped; R10 count readback while idle
        cyc(1'b0, 1'b1, 3'd0, 32'h7FFF_FFFF);
        rd(3'd0, v); check("R1 readback", v, exp_val(1'b0, 1'b1, 29'h1FFF_FFFF));
        rd(3'd4, v); check("R10 idle count", v, exp_ctl(1'b0, 29'h1FFF_FFFF));
        cyc(1'b1, 1'b0, 3'd0, 32'd0);
        check("R6 unarmed no irq", {31'd0, irq}, 32'd0);

        // R3 count zero
        cyc(1'b0, 1'b1, 3'd0, ARM);
        rd(3'd0, v); check("R1 armed readback", v, exp_val(1'b1, 1'b0, 29'd0));
        check("R3 no irq before strobe", {31'd0, irq}, 32'd0);
        cyc(1'b0, 1'b0, 3'd0, 32'd0);
        check("R2 no strobe no expiry", {31'd0, irq}, 32'd0);
        cyc(1'b1, 1'b0, 3'd0, 32'd0);
        check("R3 first strobe expires", {31'd0, irq}, 32'd1);
        rd(3'd4, v); check("R10 pending flag", v, exp_ctl(1'b1, 29'd0));

        // R7 ack with bit 30 clear does nothing
        cyc(1'b0, 1'b1, 3'd4, 32'hBFFF_FFFF);
        check("R7 non-ack write", {31'd0, irq}, 32'd1);
        ack();
        check("R7 ack", {31'd0, irq}, 32'd0);

        // R4 no further irq after single-shot
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 3'd0, 32'd0);
        check("R4 stays quiet", {31'd0, irq}, 32'd0);

        // R8 expiry beats ack
        cyc(1'b0, 1'b1, 3'd0, ARM);
        cyc(1'b1, 1'b0, 3'd0, 32'd0);
        cyc(1'b0, 1'b1, 3'd0, ARM);
        cyc(1'b1, 1'b1, 3'd4, ACK);
        check("R8 expiry wins", {31'd0, irq}, 32'd1);
        ack();
        check("R8 later ack", {31'd0, irq}, 32'd0);

        // R10 remaining count
        cyc(1'b0, 1'b1, 3'd0, ARM | 32'd9);
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 3'd0, 32'd0);
        rd(3'd4, v); check("R10 remaining", v, exp_ctl(1'b0, 29'd5));

        // R9 rewrite restarts; strobe in the write cycle ignored
        cyc(1'b1, 1'b1, 3'd0, ARM | 32'd2);
        rd(3'd4, v); check("R9 restart count", v, exp_ctl(1'b0, 29'd2));
        cyc(1'b1, 1'b0, 3'd0, 32'd0);
        cyc(1'b1, 1'b0, 3'd0, 32'd0);
        check("R9 not yet", {31'd0, irq}, 32'd0);
        cyc(1'b1, 1'b0, 3'd0, 32'd0);
        check("R9 expiry", {31'd0, irq}, 32'd1);
        ack();

        // R6 stop by writing zero
        cyc(1'b0, 1'b1, 3'd0, ARM | 32'd2);
        cyc(1'b1, 1'b0, 3'd0, 32'd0);
        cyc(1'b0, 1'b1, 3'd0, 32'd0);
        for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, 3'd0, 32'd0);
        check("R6 stopped", {31'd0, irq}, 32'd0);
        rd(3'd0, v); check("R6 disarmed", v, 32'd0);

        // R12 undecoded offset ignored
        cyc(1'b0, 1'b1, 3'd2, ARM);
        rd(3'd0, v); check("R12 write ignored", v, 32'd0);
        rd(3'd2, v); check("R12 read zero", v, 32'd0);
        cyc(1'b1, 1'b0, 3'd0, 32'd0);
        check("R12 no irq", {31'd0, irq}, 32'd0);

        // R5 repeat mode: three periods of 4 strobes
        cyc(1'b0, 1'b1, 3'd0, ARM | RPT | 32'd3);
        for (int p = 0; p < 3; p++) begin
            for (int k = 1; k <= 4; k++) begin
                gap();
                cyc(1'b1, 1'b0, 3'd0, 32'd0);
                check(k < 4 ? "R5 mid period" : "R5 period end", {31'd0, irq}, {31'd0, k == 4});
            end
            rd(3'd0, v); check("R5 still armed", v, exp_val(1'b1, 1'b1, 29'd3));
            ack();
        end
        cyc(1'b0, 1'b1, 3'd0, 32'd0);

        // R2 random single-shot runs
        for (int r = 0; r < 20; r++) run_oneshot($urandom_range(0, 15));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule